// File: doc/BRIEF.md
# NAND Step Hamming Parity Accumulator

This block sits beside the byte path of a NAND flash controller and builds single-error-correcting Hamming parity over the data area of a page. The page is handled one fixed step at a time. A step is `STEP_BYTES` bytes, 256 by default. Each byte offered with `byte_vld` is folded into the running parity while `ecc_en` is high. The same logic serves reads and writes, because it only watches the byte stream. When the last byte of a step is taken, the finished parity word is latched into a capture register and flagged valid. The running state then restarts for the next step.

Software, or a sequencer, collects each captured word with a one-cycle `cap_rd`. The block also presents the word in the 3-byte form that is written to the spare area, which is the inverted parity word shifted left by two. An `ecc_clr` pulse zeroes the running parity before a new transfer. A separate transfer counter is loaded with the byte count of the data area. It counts down on every byte, shows when bytes are still owed, and pulses when the count reaches zero.

Top module: `nand_step_ecc_acc`

## Requirements
- R1: After reset, `cap_vld`, `tc_busy` and `tc_done` are 0 and `tc_remain` is 0.
- R2: A step's parity word has column parity in bits [5:0] and line parity above it. For bit-position bit k (k = 0..2), bit 2k is the XOR of all data bits whose position within the byte has bit k = 0, and bit 2k+1 is the XOR of those with bit k = 1. For byte-address bit a (a = 0..7 for 256-byte steps), bit 6+2a is the XOR of all bits of the bytes whose offset in the step has bit a = 0, and bit 6+2a+1 is the XOR of those with bit a = 1. The word is 22 bits wide at the default step size.
- R3: A byte is accepted when `byte_vld` and `ecc_en` are both high. On the clock edge that accepts the last byte of a step, `cap_word` takes that step's parity and `cap_vld` goes to 1. The next step starts from zero parity, and no capture happens at any other time.
- R4: `cap_vld` stays 1 until `cap_rd` is sampled high, and the edge that samples `cap_rd` clears it. `cap_word` changes only on an edge that accepts a byte.
- R5: A byte presented while `ecc_en` is 0 changes neither the parity nor the position within the step.
- R6: `ecc_clr` zeroes the running parity and the step position. When it coincides with an accepted byte, that byte is discarded.
- R7: `cap_stored` is the bitwise inverse of `cap_word` shifted left by 2, kept to 24 bits. Bits [23:16] are the first byte stored, then [15:8], then [7:0].
- R8: `tc_load` loads `tc_val` into `tc_remain`, and a load wins over a decrement in the same cycle. Otherwise every `byte_vld` decrements a non-zero count, whatever `ecc_en` is. `tc_busy` is 1 exactly while `tc_remain` is non-zero.
- R9: `tc_done` is high for one cycle after the edge on which a byte takes the count from 1 to 0. Loading a zero count never raises it.
- R10: If a single data bit within a step is flipped, the XOR of the two parity words has exactly one bit set in each even/odd pair: 11 bits for 256-byte steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ecc_en | input | 1 | Parity accumulation enable |
| ecc_clr | input | 1 | Zero running parity and step position |
| byte_vld | input | 1 | Data byte strobe |
| byte_dat | input | 8 | Data byte |
| cap_rd | input | 1 | Acknowledge of the captured word |
| tc_load | input | 1 | Load the transfer count |
| tc_val | input | CNT_W | Transfer count to load |
| cap_vld | output | 1 | Captured word is pending |
| cap_word | output | 6+2*log2(STEP_BYTES) | Captured parity word |
| cap_stored | output | 24 (default) | Stored form, first byte in the top bits |
| tc_remain | output | CNT_W | Bytes still owed |
| tc_busy | output | 1 | Count is non-zero |
| tc_done | output | 1 | One-cycle pulse when the count reaches zero |

## Verification
A wrong step position, such as one missed by a clear or advanced by a disabled byte, shows as a capture at the wrong moment. The scoreboard flags it as an unexpected word or a mismatch as soon as that step closes, at most 256 accepted bytes later. A wrong parity bit shows in the captured word and in its stored form in the same cycle the step closes. A single-bit flip test confirms that every pair still separates the two cases. Counter faults appear at the ports on the very next edge, as a wrong remaining count, a missing or extra done pulse, or a busy flag that disagrees with the count.

// File: rtl/nse_pkg.sv
package nse_pkg;

   localparam int BYTE_W = 8;
   localparam int BPOS_W = 3;
   localparam int COL_W  = 2 * BPOS_W;

   // Even/odd parity over bit positions of an XOR-folded byte sum.
   function automatic logic [COL_W-1:0] col_parity(input logic [BYTE_W-1:0] s);
      logic [COL_W-1:0] r;
      r = '0;
      for (int k = 0; k < BPOS_W; k++) begin
         for (int i = 0; i < BYTE_W; i++) begin
            if (((i >> k) & 1) != 0) r[2*k+1] = r[2*k+1] ^ s[i];
            else                     r[2*k]   = r[2*k]   ^ s[i];
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/nse_step_acc.sv
module nse_step_acc
   import nse_pkg::*;
#(
   parameter int STEP_BYTES = 256,
   localparam int AW     = $clog2(STEP_BYTES),
   localparam int LP_W   = 2 * AW,
   localparam int WORD_W = COL_W + LP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              take,
   input  logic [BYTE_W-1:0] dat,
   output logic              step_end,
   output logic [WORD_W-1:0] nxt_word,
   output logic [AW-1:0]     pos
);

   logic [BYTE_W-1:0] col_acc, col_n;
   logic [LP_W-1:0]   lp_acc, lp_n;
   logic              bpar;

   assign bpar  = ^dat;
   assign col_n = col_acc ^ dat;

   for (genvar a = 0; a < AW; a++) begin : g_line
      assign lp_n[2*a]   = lp_acc[2*a]   ^ (bpar & ~pos[a]);
      assign lp_n[2*a+1] = lp_acc[2*a+1] ^ (bpar &  pos[a]);
   end

   assign step_end = take & ~clr & (&pos);
   assign nxt_word = {lp_n, col_parity(col_n)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         col_acc <= '0;
         lp_acc  <= '0;
         pos     <= '0;
      end else if (clr) begin
         col_acc <= '0;
         lp_acc  <= '0;
         pos     <= '0;
      end else if (take) begin
         pos <= pos + AW'(1);
         if (step_end) begin
            col_acc <= '0;
            lp_acc  <= '0;
         end else begin
            col_acc <= col_n;
            lp_acc  <= lp_n;
         end
      end
   end

endmodule

// File: rtl/nse_xfer_count.sv
module nse_xfer_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] val,
   input  logic             dec,
   output logic [CNT_W-1:0] remain,
   output logic             busy,
   output logic             done
);

   logic last;

   assign last = (remain == CNT_W'(1));
   assign busy = (remain != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
         done   <= 1'b0;
      end else begin
         done <= ~load & dec & last;
         if (load)
            remain <= val;
         else if (dec && busy)
            remain <= remain - CNT_W'(1);
      end
   end

endmodule

// File: rtl/nse_store_fmt.sv
module nse_store_fmt #(
   parameter int WORD_W = 22,
   localparam int STORE_B = (WORD_W + 2 + 7) / 8,
   localparam int STORE_W = 8 * STORE_B
) (
   input  logic [WORD_W-1:0]  word,
   output logic [STORE_W-1:0] stored
);

   logic [STORE_W-1:0] shifted;

   assign shifted = STORE_W'({word, 2'b00});

   for (genvar b = 0; b < STORE_B; b++) begin : g_byte
      assign stored[STORE_W-1-8*b -: 8] = ~shifted[STORE_W-1-8*b -: 8];
   end

endmodule

// File: rtl/nand_step_ecc_acc.sv
module nand_step_ecc_acc
   import nse_pkg::*;
#(
   parameter int STEP_BYTES = 256,
   parameter int CNT_W      = 16,
   localparam int AW      = $clog2(STEP_BYTES),
   localparam int WORD_W  = COL_W + 2 * AW,
   localparam int STORE_W = 8 * ((WORD_W + 2 + 7) / 8)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ecc_en,
   input  logic               ecc_clr,
   input  logic               byte_vld,
   input  logic [BYTE_W-1:0]  byte_dat,
   input  logic               cap_rd,
   input  logic               tc_load,
   input  logic [CNT_W-1:0]   tc_val,
   output logic               cap_vld,
   output logic [WORD_W-1:0]  cap_word,
   output logic [STORE_W-1:0] cap_stored,
   output logic [CNT_W-1:0]   tc_remain,
   output logic               tc_busy,
   output logic               tc_done
);

   if (STEP_BYTES < 2 || (STEP_BYTES & (STEP_BYTES - 1)) != 0) begin : g_bad_step
      $error("STEP_BYTES must be a power of two of at least 2");
   end
   if (CNT_W < AW + 1) begin : g_bad_cnt
      $error("CNT_W must hold at least one full step count");
   end

   logic              take;
   logic              step_end;
   logic [WORD_W-1:0] nxt_word;
   logic [AW-1:0]     step_pos;

   assign take = byte_vld & ecc_en;

   nse_step_acc #(.STEP_BYTES(STEP_BYTES)) acc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ecc_clr),
      .take     (take),
      .dat      (byte_dat),
      .step_end (step_end),
      .nxt_word (nxt_word),
      .pos      (step_pos)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_vld  <= 1'b0;
         cap_word <= '0;
      end else if (step_end) begin
         cap_vld  <= 1'b1;
         cap_word <= nxt_word;
      end else if (cap_rd) begin
         cap_vld  <= 1'b0;
      end
   end

   nse_store_fmt #(.WORD_W(WORD_W)) fmt_i (
      .word   (cap_word),
      .stored (cap_stored)
   );

   nse_xfer_count #(.CNT_W(CNT_W)) tc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (tc_load),
      .val    (tc_val),
      .dec    (byte_vld),
      .remain (tc_remain),
      .busy   (tc_busy),
      .done   (tc_done)
   );

endmodule

// File: rtl/nand_step_ecc_acc_chk.sv
module nand_step_ecc_acc_chk #(
   parameter int AW     = 8,
   parameter int WORD_W = 22,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ecc_en,
   input logic              ecc_clr,
   input logic              byte_vld,
   input logic              cap_rd,
   input logic              tc_load,
   input logic [CNT_W-1:0]  tc_val,
   input logic              cap_vld,
   input logic [WORD_W-1:0] cap_word,
   input logic [CNT_W-1:0]  tc_remain,
   input logic              tc_busy,
   input logic              tc_done,
   input logic [AW-1:0]     step_pos
);

   a_r3_vld_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cap_vld) |-> $past(byte_vld && ecc_en));

   a_r4_vld_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cap_vld && !cap_rd |=> cap_vld);

   a_r4_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_vld && ecc_en) |=> $stable(cap_word));

   a_r5_pos_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_vld && ecc_en) && !ecc_clr |=> $stable(step_pos));

   a_r6_clr_pos: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_clr |=> step_pos == '0);

   a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
      tc_load |=> tc_remain == $past(tc_val));

   a_r8_dec: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld && tc_busy && !tc_load |=> tc_remain == $past(tc_remain) - CNT_W'(1));

   a_r9_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
      tc_done |-> (tc_remain == '0) && !tc_busy);

   a_r9_fell_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tc_busy) |-> tc_done || $past(tc_load));

endmodule

bind nand_step_ecc_acc nand_step_ecc_acc_chk #(
   .AW(AW), .WORD_W(WORD_W), .CNT_W(CNT_W)
) chk_i (
   .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .ecc_clr(ecc_clr),
   .byte_vld(byte_vld), .cap_rd(cap_rd), .tc_load(tc_load), .tc_val(tc_val),
   .cap_vld(cap_vld), .cap_word(cap_word), .tc_remain(tc_remain),
   .tc_busy(tc_busy), .tc_done(tc_done), .step_pos(step_pos)
);

// File: tb/nand_step_ecc_acc_tb_top.sv
module nand_step_ecc_acc_tb_top;

   localparam int STEP = 256;
   localparam int CW   = 16;
   localparam int WW   = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ecc_en = 1'b1, ecc_clr = 1'b0, byte_vld = 1'b0;
   logic [7:0]    byte_dat = '0;
   logic          cap_rd = 1'b0, tc_load = 1'b0;
   logic [CW-1:0] tc_val = '0;
   logic          cap_vld;
   logic [WW-1:0] cap_word;
   logic [23:0]   cap_stored;
   logic [CW-1:0] tc_remain;
   logic          tc_busy, tc_done;

   int n_chk = 0, n_fail = 0;
   logic [WW-1:0] exp_q[$];
   logic [7:0]    sbuf[STEP];
   int            spos = 0;
   int            tc_m = 0;
   bit            mon_hold = 1'b0;
   logic [WW-1:0] last_word = '0;
   int            n_cap = 0;

   always #10 clk = ~clk;

   nand_step_ecc_acc #(.STEP_BYTES(STEP), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en), .ecc_clr(ecc_clr),
      .byte_vld(byte_vld), .byte_dat(byte_dat), .cap_rd(cap_rd),
      .tc_load(tc_load), .tc_val(tc_val), .cap_vld(cap_vld),
      .cap_word(cap_word), .cap_stored(cap_stored), .tc_remain(tc_remain),
      .tc_busy(tc_busy), .tc_done(tc_done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Parity from its definition, bit by bit (R2).
   function automatic logic [WW-1:0] ref_word();
      logic [5:0]  c = '0;
      logic [15:0] l = '0;
      for (int i = 0; i < STEP; i++)
         for (int j = 0; j < 8; j++)
            if (sbuf[i][j]) begin
               for (int k = 0; k < 3; k++) c[2*k + ((j >> k) & 1)] ^= 1'b1;
               for (int a = 0; a < 8; a++) l[2*a + ((i >> a) & 1)] ^= 1'b1;
            end
      return {l, c};
   endfunction

   task automatic put(input logic [7:0] b, input bit en);
      byte_vld = 1'b1; byte_dat = b; ecc_en = en;
      if (tc_m != 0) tc_m--;
      if (en) begin
         sbuf[spos] = b;
         spos++;
         if (spos == STEP) begin
            exp_q.push_back(ref_word());
            spos = 0;
         end
      end
      @(negedge clk);
      byte_vld = 1'b0; ecc_en = 1'b1;
   endtask

   task automatic load(input int v);
      tc_load = 1'b1; tc_val = CW'(v); tc_m = v;
      @(negedge clk);
      tc_load = 1'b0;
      chk(tc_remain == CW'(v), "R8", "loaded count", 32'(tc_remain), 32'(v));
      chk(tc_busy == (v != 0), "R8", "busy after load", 32'(tc_busy), 32'(v != 0));
   endtask

   task automatic step_rand();
      for (int i = 0; i < STEP; i++) put(8'($urandom), 1'b1);
   endtask

   // Scoreboard monitor.
   initial begin
      forever begin
         @(negedge clk);
         if (cap_rd) cap_rd = 1'b0;
         else if (rst_n && cap_vld && !mon_hold) begin
            n_cap++;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3", "unexpected capture", 32'(cap_word), 32'h0);
            end else begin
               logic [WW-1:0] e;
               e = exp_q.pop_front();
               chk(cap_word == e, "R2", "parity word", 32'(cap_word), 32'(e));
               chk(cap_stored == ~24'({e, 2'b00}), "R7", "stored form",
                   32'(cap_stored), 32'(~24'({e, 2'b00})));
            end
            last_word = cap_word;
            cap_rd = 1'b1;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [WW-1:0] wa, wb, x;
      int ones;
      repeat (3) @(negedge clk);
      chk(cap_vld == 1'b0, "R1", "cap_vld in reset", 32'(cap_vld), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cap_vld == 1'b0 && tc_busy == 1'b0 && tc_done == 1'b0, "R1", "flags after reset",
          32'({cap_vld, tc_busy, tc_done}), 0);
      chk(tc_remain == '0, "R1", "count after reset", 32'(tc_remain), 0);

      // Zero step with count of one step.
      load(STEP);
      for (int i = 0; i < STEP; i++) put(8'h00, 1'b1);
      chk(tc_done == 1'b1, "R9", "done after last byte", 32'(tc_done), 1);
      chk(tc_remain == '0 && !tc_busy, "R8", "count empty", 32'(tc_remain), 0);
      @(negedge clk);
      chk(tc_done == 1'b0, "R9", "done is one cycle", 32'(tc_done), 0);

      // Page of four random steps.
      load(4 * STEP);
      for (int s = 0; s < 4; s++) begin
         step_rand();
         if (s == 1) chk(tc_remain == CW'(tc_m), "R8", "mid-page count", 32'(tc_remain), 32'(tc_m));
      end
      chk(tc_done == 1'b1, "R9", "page done", 32'(tc_done), 1);

      // Single set bit: byte 0x10 at offset 0xA5.
      for (int i = 0; i < STEP; i++) put((i == 'hA5) ? 8'h10 : 8'h00, 1'b1);
      repeat (2) @(negedge clk);
      chk(last_word == 22'h2659A5, "R2", "single bit word", 32'(last_word), 32'h2659A5);

      // Single-bit correction signature.
      begin
         logic [7:0] keep[STEP];
         for (int i = 0; i < STEP; i++) keep[i] = 8'($urandom);
         for (int i = 0; i < STEP; i++) put(keep[i], 1'b1);
         repeat (2) @(negedge clk);
         wa = last_word;
         keep[77] = keep[77] ^ 8'h08;
         for (int i = 0; i < STEP; i++) put(keep[i], 1'b1);
         repeat (2) @(negedge clk);
         wb = last_word;
      end
      x = wa ^ wb;
      ones = 0;
      for (int p = 0; p < WW / 2; p++) if (x[2*p] ^ x[2*p+1]) ones++;
      chk(ones == WW / 2 && $countones(x) == WW / 2, "R10", "syndrome pairs",
          32'($countones(x)), 32'(WW / 2));

      // Disabled bytes interleaved; count still tracks all bytes.
      load(STEP + 100);
      for (int i = 0; i < STEP; i++) begin
         put(8'($urandom), 1'b1);
         if (i % 3 == 0 && i < 300) put(8'hFF, 1'b0);
      end
      while (tc_m != 0) put(8'h5A, 1'b0);
      chk(tc_done == 1'b1, "R5", "disabled bytes still counted", 32'(tc_done), 1);
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R5", "step closed on enabled bytes only", 32'(exp_q.size()), 0);

      // Clear mid-step, coinciding with a byte.
      for (int i = 0; i < 50; i++) put(8'($urandom), 1'b1);
      ecc_clr = 1'b1; byte_vld = 1'b1; byte_dat = 8'hC3;
      @(negedge clk);
      ecc_clr = 1'b0; byte_vld = 1'b0;
      spos = 0;
      for (int i = 0; i < STEP - 1; i++) put(8'($urandom), 1'b1);
      repeat (2) @(negedge clk);
      chk(cap_vld == 1'b0 && exp_q.size() == 0, "R6", "no capture before full step",
          32'(cap_vld), 0);
      put(8'h81, 1'b1);
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R6", "capture after clear", 32'(exp_q.size()), 0);

      // Hold without read.
      mon_hold = 1'b1;
      step_rand();
      repeat (6) @(negedge clk);
      chk(cap_vld == 1'b1, "R4", "valid held without read", 32'(cap_vld), 1);
      chk(exp_q.size() == 1 && cap_word == exp_q[0], "R4", "word held",
          32'(cap_word), 32'(exp_q[0]));
      put(8'h3C, 1'b0);
      chk(cap_vld == 1'b1, "R4", "held across disabled byte", 32'(cap_vld), 1);
      mon_hold = 1'b0;
      repeat (3) @(negedge clk);
      chk(cap_vld == 1'b0, "R4", "read clears valid", 32'(cap_vld), 0);

      // Counter corners.
      load(0);
      @(negedge clk);
      chk(tc_done == 1'b0, "R9", "no done on zero load", 32'(tc_done), 0);
      load(1);
      tc_load = 1'b1; tc_val = CW'(5); byte_vld = 1'b1; ecc_en = 1'b0; tc_m = 5;
      @(negedge clk);
      tc_load = 1'b0; byte_vld = 1'b0; ecc_en = 1'b1;
      chk(tc_remain == CW'(5) && tc_done == 1'b0, "R8", "load wins over byte",
          32'(tc_remain), 5);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R3", "all steps captured", 32'(exp_q.size()), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule